// File: doc/BRIEF.md
# Dual-Channel Byte-Loaded Converter Code Interface

This block sits between an 8-bit parallel write bus and a two-channel 12-bit converter core. Each channel's 12-bit code is built in two pieces: a full low byte and a 4-bit high part. Two address bits choose the channel and the piece. Chip select and write strobe the load. Both assembled input words wait in a first register stage. A separate update strobe then copies both words into the output stage in one action, so the two channel codes change together.

When update, chip select and write are all active together, the block is transparent. The output stage takes the input words, including the byte written in that same cycle. An asynchronous active-low clear empties every register at once and overrides every other control. All latching is modelled with registers sampled on the rising edge of a system clock.

Top module: `dual_dac_byteload_if`

## Requirements
- R1: While `clr_n` is low, both input words and both output codes are zero. Clearing takes effect without waiting for a clock edge.
- R2: A clock edge with `cs_n`=0, `wr_n`=0 and `addr`=2'b00 loads all 8 bus bits into bits 7..0 of the channel A input word. Bits 11..8 of that word are left unchanged.
- R3: `addr`=2'b01 under the same strobes loads bus bits 3..0 into bits 11..8 of the channel A input word, with bus bit 3 landing in bit 11 (the MSB).
- R4: `addr`=2'b10 loads the channel B low byte and `addr`=2'b11 loads the channel B high part, following the bit rules of R2 and R3.
- R5: A clock edge with `upd_n`=0, `wr_n`=0 and `cs_n`=1 copies both input words into both output codes. The new codes are visible after that edge.
- R6: With `upd_n`, `cs_n` and `wr_n` all 0 at an edge, the output codes after that edge equal the input words after that edge, including any byte written at it.
- R7: With `wr_n`=1, an edge changes neither input words nor output codes.
- R8: With `cs_n`=1 and `upd_n`=1, an edge changes neither input words nor output codes.
- R9: During a high-part write, bus bits 7..4 have no effect.
- R10: While `upd_n`=1, the output codes hold their value even as the input words are rewritten.
- R11: A fall of `clr_n` in the middle of a write cycle zeroes the outputs at once. The partly written data is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all registers |
| clr_n | input | 1 | Asynchronous clear, active low |
| bus_d | input | 8 | Parallel write data |
| addr | input | 2 | Bit 1 selects the channel (0 = A), bit 0 selects the high part |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| upd_n | input | 1 | Update strobe, active low |
| code_a | output | 12 | Channel A output code |
| code_b | output | 12 | Channel B output code |

## Verification
The input words cannot be seen at the ports until a transfer. A bad byte or nibble steering therefore stays hidden until the next update or transparent cycle. It then shows as a wrong code on one channel, one clock after that update edge. A spurious transfer shows as an output change one clock after a cycle that should have held, which is why every idle and hold cycle is followed by an output comparison. Input words that are not cleared only show up after a later update following the clear.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int BUS_W  = 8;
  localparam int CODE_W = 12;
  localparam int NCHAN  = 2;

  // Place one bus piece into a code word: the low byte or the high part.
  function automatic logic [CODE_W-1:0] merge_piece(
    input logic [CODE_W-1:0] word,
    input logic              hi_sel,
    input logic [BUS_W-1:0]  data
  );
    logic [CODE_W-1:0] res;
    res = word;
    if (hi_sel) res[CODE_W-1:BUS_W] = data[CODE_W-BUS_W-1:0];
    else        res[BUS_W-1:0]      = data;
    return res;
  endfunction
endpackage

// File: rtl/dacif_ctrl.sv
module dacif_ctrl #(
  parameter int NCH = dacif_pkg::NCHAN,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W = CH_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              upd_n,
  output logic [NCH-1:0]    ld_lo,
  output logic [NCH-1:0]    ld_hi,
  output logic              xfer
);
  logic wr_sel;
  assign wr_sel = !cs_n && !wr_n;
  assign xfer   = !upd_n && !wr_n;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_dec
    logic hit;
    assign hit       = wr_sel && (addr[ADDR_W-1:1] == CH_W'(ch));
    assign ld_lo[ch] = hit && !addr[0];
    assign ld_hi[ch] = hit &&  addr[0];
  end
endmodule

// File: rtl/dacif_inreg.sv
module dacif_inreg #(
  parameter int BW = dacif_pkg::BUS_W,
  parameter int CW = dacif_pkg::CODE_W
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [BW-1:0] bus_d,
  output logic [CW-1:0] word_q,
  output logic [CW-1:0] word_nxt
);
  always_comb begin
    word_nxt = word_q;
    if (ld_lo || ld_hi) word_nxt = dacif_pkg::merge_piece(word_q, ld_hi, bus_d);
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) word_q <= '0;
    else        word_q <= word_nxt;
  end
endmodule

// File: rtl/dacif_outreg.sv
module dacif_outreg #(
  parameter int CW = dacif_pkg::CODE_W
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          xfer,
  input  logic [CW-1:0] din,
  output logic [CW-1:0] dout
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)    dout <= '0;
    else if (xfer) dout <= din;
  end
endmodule

// File: rtl/dual_dac_byteload_if.sv
module dual_dac_byteload_if (
  input  logic        clk,
  input  logic        clr_n,
  input  logic [7:0]  bus_d,
  input  logic [1:0]  addr,
  input  logic        cs_n,
  input  logic        wr_n,
  input  logic        upd_n,
  output logic [11:0] code_a,
  output logic [11:0] code_b
);
  localparam int NCH = dacif_pkg::NCHAN;
  localparam int BW  = dacif_pkg::BUS_W;
  localparam int CW  = dacif_pkg::CODE_W;

  logic [NCH-1:0] ld_lo, ld_hi;
  logic           xfer;
  logic [CW-1:0]  word_q   [NCH];
  logic [CW-1:0]  word_nxt [NCH];
  logic [CW-1:0]  code_q   [NCH];
  logic [CW-1:0]  word_a, word_b;

  dacif_ctrl #(.NCH(NCH)) ctrl_i (
    .addr (addr),
    .cs_n (cs_n),
    .wr_n (wr_n),
    .upd_n(upd_n),
    .ld_lo(ld_lo),
    .ld_hi(ld_hi),
    .xfer (xfer)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    dacif_inreg #(.BW(BW), .CW(CW)) inreg_i (
      .clk     (clk),
      .clr_n   (clr_n),
      .ld_lo   (ld_lo[ch]),
      .ld_hi   (ld_hi[ch]),
      .bus_d   (bus_d),
      .word_q  (word_q[ch]),
      .word_nxt(word_nxt[ch])
    );
    // The next-state word is what makes the transparent case include this cycle's byte.
    dacif_outreg #(.CW(CW)) outreg_i (
      .clk  (clk),
      .clr_n(clr_n),
      .xfer (xfer),
      .din  (word_nxt[ch]),
      .dout (code_q[ch])
    );
  end

  assign word_a = word_q[0];
  assign word_b = word_q[1];
  assign code_a = code_q[0];
  assign code_b = code_q[1];
endmodule

// File: rtl/dacif_chk.sv
module dacif_chk (
  input logic        clk,
  input logic        clr_n,
  input logic [7:0]  bus_d,
  input logic [1:0]  addr,
  input logic        cs_n,
  input logic        wr_n,
  input logic        upd_n,
  input logic [11:0] code_a,
  input logic [11:0] code_b,
  input logic [11:0] word_a,
  input logic [11:0] word_b
);
  // R1
  clr_zero_chk: assert property (@(posedge clk)
    !clr_n |-> (code_a == 12'h0 && code_b == 12'h0 && word_a == 12'h0 && word_b == 12'h0));

  // R2
  a_lo_load_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!cs_n && !wr_n && addr == 2'b00) |=>
      (word_a[7:0] == $past(bus_d) && word_a[11:8] == $past(word_a[11:8])));

  // R3
  a_hi_load_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!cs_n && !wr_n && addr == 2'b01) |=>
      (word_a[11:8] == $past(bus_d[3:0]) && word_a[7:0] == $past(word_a[7:0])));

  // R4
  b_hi_load_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!cs_n && !wr_n && addr == 2'b11) |=>
      (word_b[11:8] == $past(bus_d[3:0]) && word_b[7:0] == $past(word_b[7:0])));

  // R5
  upd_copy_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!upd_n && !wr_n && cs_n) |=> (code_a == $past(word_a) && code_b == $past(word_b)));

  // R6
  transparent_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!upd_n && !wr_n && !cs_n) |=> (code_a == word_a && code_b == word_b));

  // R7
  wr_idle_chk: assert property (@(posedge clk) disable iff (!clr_n)
    wr_n |=> ($stable(code_a) && $stable(code_b) && $stable(word_a) && $stable(word_b)));

  // R8
  cs_upd_idle_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (cs_n && upd_n) |=> ($stable(code_a) && $stable(code_b) && $stable(word_a) && $stable(word_b)));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    upd_n |=> ($stable(code_a) && $stable(code_b)));
endmodule

bind dual_dac_byteload_if dacif_chk chk_i (
  .clk   (clk),
  .clr_n (clr_n),
  .bus_d (bus_d),
  .addr  (addr),
  .cs_n  (cs_n),
  .wr_n  (wr_n),
  .upd_n (upd_n),
  .code_a(code_a),
  .code_b(code_b),
  .word_a(word_a),
  .word_b(word_b)
);

// File: tb/dual_dac_byteload_if_tb_top.sv
module dual_dac_byteload_if_tb_top;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    string       tag;
    logic [11:0] a;
    logic [11:0] b;
  } exp_t;

  logic        clk = 1'b0;
  logic        clr_n = 1'b0;
  logic [7:0]  bus_d = 8'h00;
  logic [1:0]  addr = 2'b00;
  logic        cs_n = 1'b1, wr_n = 1'b1, upd_n = 1'b1;
  logic [11:0] code_a, code_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t sb[$];

  logic [11:0] m_word [2];
  logic [11:0] m_out  [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dac_byteload_if dut_i (
    .clk(clk), .clr_n(clr_n), .bus_d(bus_d), .addr(addr),
    .cs_n(cs_n), .wr_n(wr_n), .upd_n(upd_n),
    .code_a(code_a), .code_b(code_b)
  );

  task automatic compare(string tag, logic [11:0] a, logic [11:0] b);
    checks++;
    if (code_a !== a || code_b !== b) begin
      fails++;
      $display("FAIL %s: code_a=%h code_b=%h expected a=%h b=%h", tag, code_a, code_b, a, b);
    end
  endtask

  // Driver: apply one bus cycle, update the model after the edge, queue the expectation.
  task automatic cyc(input logic [7:0] d, input logic [1:0] ad,
                     input logic c, input logic w, input logic u, input string tag);
    @(negedge clk);
    bus_d = d; addr = ad; cs_n = c; wr_n = w; upd_n = u;
    @(posedge clk);
    if (!c && !w) begin
      if (ad[0]) m_word[ad[1]][11:8] = d[3:0];
      else       m_word[ad[1]][7:0]  = d;
    end
    if (!u && !w) begin
      m_out[0] = m_word[0];
      m_out[1] = m_word[1];
    end
    sb.push_back('{tag, m_out[0], m_out[1]});
  endtask

  // Monitor: compare queued expectations away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        compare(e.tag, e.a, e.b);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    m_word[0] = '0; m_word[1] = '0; m_out[0] = '0; m_out[1] = '0;
    repeat (2) @(posedge clk);
    #1 compare("R1 reset", 12'h000, 12'h000);
    @(negedge clk); clr_n = 1'b1;

    cyc(8'h5A, 2'b00, 0, 0, 1, "R2 A low byte, R10 outputs hold");
    cyc(8'hF3, 2'b01, 0, 0, 1, "R3 R9 A high part, upper bus bits ignored");
    cyc(8'hC4, 2'b10, 0, 0, 1, "R4 B low byte");
    cyc(8'h6A, 2'b11, 0, 0, 1, "R4 R9 B high part");
    cyc(8'h00, 2'b00, 1, 0, 0, "R5 update copies both words");
    cyc(8'h11, 2'b00, 0, 0, 1, "R10 rewrite A low, outputs hold");
    cyc(8'hEE, 2'b00, 1, 0, 1, "R8 cs and update high ignored");
    cyc(8'h77, 2'b01, 0, 1, 0, "R7 write high ignored");
    cyc(8'h00, 2'b00, 1, 0, 0, "R5 R7 R8 update shows input words");
    cyc(8'h05, 2'b11, 0, 0, 0, "R6 transparent B high part");
    cyc(8'h99, 2'b00, 0, 0, 0, "R6 transparent A low byte");
    cyc(8'hF8, 2'b01, 0, 0, 1, "R3 MSB placement");
    cyc(8'h00, 2'b00, 1, 0, 0, "R3 R5 update with MSB set");
    cyc(8'h00, 2'b00, 1, 1, 1, "R7 idle cycle");

    // R11: clear in the middle of a write cycle
    @(negedge clk);
    bus_d = 8'hAB; addr = 2'b10; cs_n = 1'b0; wr_n = 1'b0; upd_n = 1'b0;
    #2 clr_n = 1'b0;
    #1 compare("R11 async clear mid write", 12'h000, 12'h000);
    m_word[0] = '0; m_word[1] = '0; m_out[0] = '0; m_out[1] = '0;
    @(posedge clk);
    #1 compare("R1 held in clear", 12'h000, 12'h000);
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1; upd_n = 1'b1; clr_n = 1'b1;
    cyc(8'h00, 2'b00, 1, 0, 0, "R1 input words cleared");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule